// File: doc/BRIEF.md
# Divider Programming Load Interface

This block is the configuration front end of a frequency synthesizer. It holds a 9-bit feedback divider value, a 2-bit output divider code and a 2-bit test-select field. These values can be written two ways. The first is a wide parallel bus, qualified by an active-low strobe. The second is a three-wire serial path made of a shift clock, a data line and a load strobe. The divider values drive the analog loop, which is outside this block.

All strobes and the serial data line are asynchronous. Each passes through a two-flop synchronizer into the system clock domain, and the block acts on the edges it detects there. The parallel data bus is treated as quasi-static and is sampled directly. A diagnostic output selects one of four sources according to the test field. The sources are a constant low, the serial data line, the feedback-divided clock and the output clock. A status flag reports when the feedback value lies outside the range the loop can lock to.

Top module: `dpl_prog_if`

## Requirements
- R1: While reset is asserted, and after it is released, the configuration holds feedback value 16, output code 0 and test field 00. The range flag and the test output are low.
- R2: While the parallel strobe is low, the feedback value and output code follow the parallel bus within 3 system clock edges. The test field is forced to 00, so the test output stays low.
- R3: A rising parallel strobe captures the bus. Later bus changes while the strobe stays high do not alter the configuration.
- R4: With the parallel strobe high and the serial load low, each rising shift clock shifts one data bit into a 13-bit shift register. The configuration stays unchanged.
- R5: The serial frame is sent MSB first in the order T1, T0, N1, N0, then M8 down to M0. After 13 shifts, M0 sits in bit 0.
- R6: A rising serial load copies the shift register into the configuration. Once the load is low again, further shifting leaves the configuration unchanged.
- R7: While the serial load is held high, each rising shift clock shifts, and the configuration takes the new shift-register value.
- R8: When the shift clock and the serial load rise in the same system cycle, the load is performed and no shift occurs.
- R9: The test output is selected by the test field {T1,T0}: 00 gives low, 01 gives the synchronized serial data, 10 gives the feedback-divided clock, and 11 gives the output clock.
- R10: The range flag is high exactly when the feedback value is below 8 or above 28.
- R11: While the parallel strobe is low, serial clock and load activity have no effect on the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_load_n | input | 1 | Parallel strobe, active low, asynchronous |
| par_m_i | input | 9 | Parallel feedback divider value |
| par_n_i | input | 2 | Parallel output divider code |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_load | input | 1 | Serial load strobe, asynchronous |
| fb_div_clk | input | 1 | Feedback-divided clock, for observation |
| out_clk | input | 1 | Output clock, for observation |
| m_val | output | 9 | Feedback divider value |
| n_code | output | 2 | Output divider code |
| test_out | output | 1 | Diagnostic mux output |
| m_range_err | output | 1 | Feedback value outside lockable range |

## Verification
A wrong shift-register bit stays hidden until the next serial load or the next shift with the load held high. It then shows up on m_val, n_code or test_out about three system cycles after the strobe edge. A fault in the configuration register shows on the divider outputs and the range flag three cycles after the triggering edge. Because the shift register is hidden, the bench keeps its own frame model, so that a missing or extra shift is caught at the next transfer. A wrong test field shows immediately on test_out once the selected source is toggled.

// File: rtl/dpl_pkg.sv
package dpl_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 2;
  localparam int FRAME_W = T_W + N_W + M_W;

  // Field order equals the serial frame order, MSB first.
  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;
endpackage

// File: rtl/dpl_sync.sv
module dpl_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dpl_edge.sv
module dpl_edge #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/dpl_shift.sv
module dpl_shift
  import dpl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               din,
  output logic [FRAME_W-1:0] sh_q,
  output logic [FRAME_W-1:0] sh_nx
);
  always_comb begin
    sh_nx = sh_q;
    if (shift_en) sh_nx = {sh_q[FRAME_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nx;
  end
endmodule

// File: rtl/dpl_cfg_reg.sv
module dpl_cfg_reg
  import dpl_pkg::*;
#(
  parameter int DEF_M = 16,
  parameter int DEF_N = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               par_take,
  input  logic [M_W-1:0]     par_m,
  input  logic [N_W-1:0]     par_n,
  input  logic               ser_xfer,
  input  logic               ser_follow,
  input  logic [FRAME_W-1:0] sh_q,
  input  logic [FRAME_W-1:0] sh_nx,
  output cfg_t               cfg_q
);
  localparam cfg_t CFG_DEF = '{t: '0, n: N_W'(DEF_N), m: M_W'(DEF_M)};

  cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (par_take) begin
      cfg_d.t = '0;
      cfg_d.n = par_n;
      cfg_d.m = par_m;
    end else if (ser_xfer) begin
      cfg_d = cfg_t'(sh_q);
    end else if (ser_follow) begin
      cfg_d = cfg_t'(sh_nx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_DEF;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/dpl_test_mux.sv
module dpl_test_mux
  import dpl_pkg::*;
(
  input  logic [T_W-1:0] sel,
  input  logic           ser_in,
  input  logic           fb_clk,
  input  logic           o_clk,
  output logic           y
);
  always_comb begin
    unique case (sel)
      2'b01:   y = ser_in;
      2'b10:   y = fb_clk;
      2'b11:   y = o_clk;
      default: y = 1'b0;
    endcase
  end
endmodule

// File: rtl/dpl_prog_if.sv
module dpl_prog_if
  import dpl_pkg::*;
#(
  parameter int DEF_M       = 16,
  parameter int DEF_N       = 0,
  parameter int M_MIN       = 8,
  parameter int M_MAX       = 28,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_n_i,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  input  logic           fb_div_clk,
  input  logic           out_clk,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_code,
  output logic           test_out,
  output logic           m_range_err
);
  localparam int          STB_W   = 3;
  localparam logic [2:0]  STB_RST = 3'b100; // {par_load_n, ser_load, ser_clk}

  logic [STB_W-1:0]   stb_s, stb_rise;
  logic               data_s;
  logic               par_hi, par_rise, ld_s, ld_rise, sclk_rise;
  logic               ser_ok, shift_en, follow_en, par_take, xfer_en;
  logic [FRAME_W-1:0] sh_q, sh_nx;
  cfg_t               cfg_q;

  dpl_sync #(.W(STB_W), .STAGES(SYNC_STAGES), .RST_VAL(STB_RST)) u_stb_sync (
    .clk(clk), .rst_n(rst_n),
    .d({par_load_n, ser_load, ser_clk}), .q(stb_s)
  );

  dpl_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_data_sync (
    .clk(clk), .rst_n(rst_n), .d(ser_data), .q(data_s)
  );

  dpl_edge #(.W(STB_W), .RST_VAL(STB_RST)) u_stb_edge (
    .clk(clk), .rst_n(rst_n), .lvl(stb_s), .rise(stb_rise)
  );

  assign par_hi    = stb_s[2];
  assign ld_s      = stb_s[1];
  assign par_rise  = stb_rise[2];
  assign ld_rise   = stb_rise[1];
  assign sclk_rise = stb_rise[0];

  // Mode decode: the parallel path wins; a load edge blocks a shift in its cycle.
  always_comb begin
    par_take  = !par_hi || par_rise;
    ser_ok    = !par_take;
    xfer_en   = ser_ok && ld_rise;
    shift_en  = ser_ok && sclk_rise && !ld_rise;
    follow_en = shift_en && ld_s;
  end

  dpl_shift u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(data_s),
    .sh_q(sh_q), .sh_nx(sh_nx)
  );

  dpl_cfg_reg #(.DEF_M(DEF_M), .DEF_N(DEF_N)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .par_take(par_take), .par_m(par_m_i), .par_n(par_n_i),
    .ser_xfer(xfer_en), .ser_follow(follow_en),
    .sh_q(sh_q), .sh_nx(sh_nx), .cfg_q(cfg_q)
  );

  dpl_test_mux u_tmux (
    .sel(cfg_q.t), .ser_in(data_s), .fb_clk(fb_div_clk), .o_clk(out_clk),
    .y(test_out)
  );

  assign m_val       = cfg_q.m;
  assign n_code      = cfg_q.n;
  assign m_range_err = (cfg_q.m < M_W'(M_MIN)) || (cfg_q.m > M_W'(M_MAX));
endmodule

// File: rtl/dpl_prog_if_chk.sv
module dpl_prog_if_chk
  import dpl_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               par_hi,
  input logic               par_rise,
  input logic               ld_s,
  input logic               ld_rise,
  input logic [M_W-1:0]     par_m_i,
  input logic [FRAME_W-1:0] sh_q,
  input cfg_t               cfg_q,
  input logic               test_out
);
  a_r2_par_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !par_hi |=> (cfg_q.m == $past(par_m_i) && cfg_q.t == '0));

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (par_hi && !par_rise && !ld_s) |=> $stable(cfg_q));

  a_r6_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (par_hi && !par_rise && ld_rise) |=> (cfg_q == cfg_t'($past(sh_q))));

  a_r8_no_shift_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rise |=> $stable(sh_q));

  a_r9_test_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.t == '0) |-> !test_out);
endmodule

bind dpl_prog_if dpl_prog_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .par_hi(par_hi), .par_rise(par_rise),
  .ld_s(ld_s), .ld_rise(ld_rise), .par_m_i(par_m_i), .sh_q(sh_q),
  .cfg_q(cfg_q), .test_out(test_out)
);

// File: tb/dpl_prog_if_bench.sv
module dpl_prog_if_bench;
  localparam int CLK_P = 10;
  localparam int NVEC  = 7;
  // {flag, n[1:0], m[8:0]}
  localparam logic [11:0] PVEC [NVEC] = '{
    {1'b1, 2'd1, 9'd7},   {1'b0, 2'd2, 9'd8},  {1'b0, 2'd3, 9'd28},
    {1'b1, 2'd0, 9'd29},  {1'b1, 2'd1, 9'd0},  {1'b1, 2'd2, 9'd511},
    {1'b0, 2'd0, 9'd16}
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       par_load_n = 1'b1, ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic       fb_div_clk = 1'b0, out_clk = 1'b0;
  logic [8:0] par_m_i = '0;
  logic [1:0] par_n_i = '0;
  logic [8:0] m_val;
  logic [1:0] n_code;
  logic       test_out, m_range_err;

  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;
  logic [12:0] mdl_sh = '0;

  always #(CLK_P/2) clk = ~clk;

  dpl_prog_if u_dpl_prog_if (
    .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .par_m_i(par_m_i),
    .par_n_i(par_n_i), .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .fb_div_clk(fb_div_clk), .out_clk(out_clk), .m_val(m_val), .n_code(n_code),
    .test_out(test_out), .m_range_err(m_range_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic chk_cfg(input string tag, input logic [12:0] exp);
    chk({tag, " m"}, 32'(m_val), 32'(exp[8:0]));
    chk({tag, " n"}, 32'(n_code), 32'(exp[10:9]));
  endtask

  task automatic ser_bit(input logic b);
    ser_data = b; settle();
    ser_clk = 1'b1; settle();
    if (par_load_n) mdl_sh = {mdl_sh[11:0], b};
    ser_clk = 1'b0; settle();
  endtask

  task automatic ser_frame(input logic [12:0] f);
    for (int i = 12; i >= 0; i--) ser_bit(f[i]);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [12:0] fa, exp_cfg;
    repeat (3) @(posedge clk); #1;
    // R1 reset state
    chk("R1 reset m", 32'(m_val), 32'd16);
    chk("R1 reset n", 32'(n_code), 32'd0);
    chk("R1 reset flag", 32'(m_range_err), 32'd0);
    chk("R1 reset test", 32'(test_out), 32'd0);
    rst_n = 1'b1; settle();
    chk("R1 after release m", 32'(m_val), 32'd16);

    // Vector table: R2 pass-through, R10 range flag, R3 capture and hold
    for (int v = 0; v < NVEC; v++) begin
      par_load_n = 1'b0; par_m_i = PVEC[v][8:0]; par_n_i = PVEC[v][10:9];
      settle();
      chk("R2 follow m", 32'(m_val), 32'(PVEC[v][8:0]));
      chk("R2 follow n", 32'(n_code), 32'(PVEC[v][10:9]));
      chk("R2 test low", 32'(test_out), 32'd0);
      chk("R10 flag", 32'(m_range_err), 32'(PVEC[v][11]));
      par_load_n = 1'b1; settle();
      par_m_i = ~PVEC[v][8:0]; par_n_i = ~PVEC[v][10:9]; settle();
      chk("R3 held m", 32'(m_val), 32'(PVEC[v][8:0]));
      chk("R3 held n", 32'(n_code), 32'(PVEC[v][10:9]));
    end

    // R4/R5: shift frame T=10 N=01 M=20, configuration unchanged
    fa = {2'b10, 2'b01, 9'd20};
    ser_frame(fa);
    chk("R4 no change while shifting m", 32'(m_val), 32'd16);
    chk("R4 no change while shifting n", 32'(n_code), 32'd0);
    ser_load = 1'b1; settle();
    chk("R5 frame order m", 32'(m_val), 32'd20);
    chk("R5 frame order n", 32'(n_code), 32'd1);
    fb_div_clk = 1'b1; settle();
    chk("R9 sel10 fb high", 32'(test_out), 32'd1);
    fb_div_clk = 1'b0; settle();
    chk("R9 sel10 fb low", 32'(test_out), 32'd0);
    ser_load = 1'b0; settle();
    ser_bit(1'b1);
    chk("R6 latched after load fall", 32'(m_val), 32'd20);

    // R8: shift clock and load rise together -> load only
    ser_data = 1'b0; settle();
    ser_clk = 1'b1; ser_load = 1'b1; settle();
    exp_cfg = mdl_sh;
    chk_cfg("R8 load no shift", exp_cfg);
    chk("R10 flag after R8", 32'(m_range_err),
        32'((exp_cfg[8:0] < 9'd8) || (exp_cfg[8:0] > 9'd28)));
    ser_clk = 1'b0; settle();

    // R7: load held high, shifts pass through
    ser_bit(1'b1);
    chk_cfg("R7 follow 1", mdl_sh);
    ser_bit(1'b0);
    chk_cfg("R7 follow 2", mdl_sh);
    ser_load = 1'b0; settle();

    // R9: test field 01 observes serial data
    ser_frame({2'b01, 2'b10, 9'd12});
    ser_load = 1'b1; settle(); ser_load = 1'b0; settle();
    chk_cfg("R6 load frame 2", {2'b01, 2'b10, 9'd12});
    ser_data = 1'b1; settle();
    chk("R9 sel01 data high", 32'(test_out), 32'd1);
    ser_data = 1'b0; settle();
    chk("R9 sel01 data low", 32'(test_out), 32'd0);

    // R9: test field 11 observes output clock
    ser_frame({2'b11, 2'b11, 9'd25});
    ser_load = 1'b1; settle(); ser_load = 1'b0; settle();
    out_clk = 1'b1; fb_div_clk = 1'b0; settle();
    chk("R9 sel11 out high", 32'(test_out), 32'd1);
    out_clk = 1'b0; fb_div_clk = 1'b1; settle();
    chk("R9 sel11 out low", 32'(test_out), 32'd0);

    // R9 field 00 after parallel mode; R2 test low; R11 serial ignored
    out_clk = 1'b1;
    par_m_i = 9'd12; par_n_i = 2'd1; par_load_n = 1'b0; settle();
    chk("R2 par clears test", 32'(test_out), 32'd0);
    chk("R2 par m", 32'(m_val), 32'd12);
    ser_frame({2'b11, 2'b00, 9'd3});
    ser_load = 1'b1; settle();
    chk("R11 serial ignored m", 32'(m_val), 32'd12);
    chk("R11 serial ignored n", 32'(n_code), 32'd1);
    ser_load = 1'b0; settle();
    par_load_n = 1'b1; settle();
    chk("R3 capture after ignore", 32'(m_val), 32'd12);

    // R1 reset mid-run
    rst_n = 1'b0; settle();
    chk("R1 mid reset m", 32'(m_val), 32'd16);
    chk("R1 mid reset n", 32'(n_code), 32'd0);
    chk("R1 mid reset test", 32'(test_out), 32'd0);
    rst_n = 1'b1; settle();
    chk("R1 mid reset flag", 32'(m_range_err), 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule